// File: doc/BRIEF.md
# Maskable Event Interrupt Controller with Pin Polarity

This block gathers eight single-cycle event pulses from a radio transceiver core into a sticky status register and drives one interrupt request pin toward a host processor. A mask register selects which recorded events may raise the pin. A poll option lets the status register also record events whose mask bit is off, so a host that runs with the pin quiet can still find out what happened by reading the status. A polarity option turns the pin into an active-low output.

The host reads the status through a small register port. Each status read clears every bit it returned. While the host drains the receive frame buffer, the block can hand the pin over to a buffer-empty flag. This flag is always active high and becomes valid a fixed number of cycles after the read burst starts. When the burst ends, the pin goes back to its interrupt role. The logic that produces the events and the buffer-empty signal lies outside this block.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the status, mask and control registers read as 0x00 and `irq_o` is low.
- R2: An event pulse on `evt_i[i]` that is recorded sets status bit i, and the bit stays set until a status read. Bit meaning: 7 low battery, 6 frame-buffer under-run, 5 address match, 4 wake-end or energy-detect-end, 3 frame end, 2 receive start, 1 PLL unlock, 0 PLL lock.
- R3: With control bit 0 (poll) clear, an event is recorded only if its mask bit was set before the clock edge that samples the event.
- R4: With control bit 0 set, every event is recorded whatever the mask, and an event that is masked off does not raise the pin.
- R5: A read at address 0 (status) returns the status and clears it at the same edge. An event sampled at that edge is kept in the new status.
- R6: With control bit 1 (polarity) clear and no buffer takeover, `irq_o` is high exactly when status AND mask is non-zero. It follows the edge that updates the status or the mask.
- R7: With control bit 1 set, the interrupt level on `irq_o` is inverted, so the pin is active low.
- R8: With control bit 2 (flag enable) set, while `fb_rd_active_i` is high `irq_o` is low until the SETTLE-th consecutive edge that samples it high. From that edge on, `irq_o` shows `fb_empty_i` as sampled at each edge, active high whatever the polarity bit.
- R9: On the first edge that samples `fb_rd_active_i` low, the pin returns to its interrupt level. With control bit 2 clear, `fb_rd_active_i` has no effect on the pin.
- R10: Writes at address 1 (mask) and address 2 (control, bits [2:0]) take effect at the next edge and read back through `rd_data_o`. Control bits [7:3] read as zero. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_i | input | 8 | Event pulses, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 1 mask, 2 control |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe; a read at address 0 clears the status |
| rd_addr_i | input | 2 | Read address: 0 status, 1 mask, 2 control |
| rd_data_o | output | 8 | Read data, combinational from the address |
| fb_rd_active_i | input | 1 | Frame-buffer read burst in progress |
| fb_empty_i | input | 1 | Frame buffer holds no valid data yet |
| irq_o | output | 1 | Interrupt request / buffer-empty pin |

## Verification
Status, mask and control registers all change at the edge that samples the stimulus, and `irq_o` is registered from the same next-state values, so every result is due right after that one edge. `rd_data_o` is combinational from the current registers. The buffer-empty flag is due after the SETTLE-th edge of a read burst and goes away at the first edge after the burst. The bench holds each stimulus across exactly one rising edge and compares its edge-stepped model against the pin and the read port at the following falling edge, so every result is observed where it is due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Register address map of the host port
  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_MASK   = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_NONE   = 2'd3
  } reg_addr_e;

  // Control register, bit 0 poll, bit 1 polarity, bit 2 flag enable
  typedef struct packed {
    logic flag_en;
    logic pol_low;
    logic poll;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // Status bit positions (decoded by host software)
  localparam int unsigned EVT_PLL_LOCK   = 0;
  localparam int unsigned EVT_PLL_UNLOCK = 1;
  localparam int unsigned EVT_RX_START   = 2;
  localparam int unsigned EVT_FRAME_END  = 3;
  localparam int unsigned EVT_WAKE_ED    = 4;
  localparam int unsigned EVT_ADDR_HIT   = 5;
  localparam int unsigned EVT_UNDERRUN   = 6;
  localparam int unsigned EVT_LOW_BATT   = 7;

endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [NUM_EVT-1:0] wr_data_i,
  output logic [NUM_EVT-1:0] mask_q_o,
  output logic [NUM_EVT-1:0] mask_d_o,
  output ctrl_t              ctrl_q_o,
  output logic               pol_d_o,
  output logic               flag_en_d_o
);

  logic  mask_en;
  logic  ctrl_en;
  ctrl_t ctrl_d;

  assign mask_en = wr_en_i && (wr_addr_i == ADDR_MASK);
  assign ctrl_en = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_comb begin
    mask_d_o = mask_q_o;
    ctrl_d   = ctrl_q_o;
    if (mask_en) mask_d_o = wr_data_i;
    if (ctrl_en) ctrl_d   = ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  assign pol_d_o     = ctrl_d.pol_low;
  assign flag_en_d_o = ctrl_d.flag_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q_o <= '0;
    end else if (mask_en) begin
      mask_q_o <= mask_d_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q_o <= '0;
    end else if (ctrl_en) begin
      ctrl_q_o <= ctrl_d;
    end
  end

endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] mask_q_i,
  input  logic               poll_i,
  input  logic               clr_i,
  output logic [NUM_EVT-1:0] status_q_o,
  output logic [NUM_EVT-1:0] status_d_o
);

  logic [NUM_EVT-1:0] rec_sel;
  logic [NUM_EVT-1:0] set_bit;

  // Poll mode lets every event through; otherwise the mask gates it
  assign rec_sel = poll_i ? {NUM_EVT{1'b1}} : mask_q_i;
  assign set_bit = evt_i & rec_sel;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    logic bit_en;

    assign bit_en = clr_i | set_bit[i];

    always_comb begin
      status_d_o[i] = status_q_o[i];
      if (clr_i)      status_d_o[i] = 1'b0;
      if (set_bit[i]) status_d_o[i] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        status_q_o[i] <= 1'b0;
      end else if (bit_en) begin
        status_q_o[i] <= status_d_o[i];
      end
    end
  end

endmodule

// File: rtl/irqc_pin.sv
module irqc_pin #(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned SETTLE  = 38
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] status_d_i,
  input  logic [NUM_EVT-1:0] mask_d_i,
  input  logic               pol_d_i,
  input  logic               flag_en_d_i,
  input  logic               fb_rd_active_i,
  input  logic               fb_empty_i,
  output logic               act_q_o,
  output logic               irq_o
);

  localparam int unsigned CNT_W   = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE);

  logic             act_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             flag_ok;
  logic             irq_req;
  logic             irq_d;

  assign act_d = fb_rd_active_i & flag_en_d_i;

  // Settle counter saturates at SETTLE, counting the sampled-high edges
  always_comb begin
    cnt_d = '0;
    if (act_d) begin
      if (cnt_q == CNT_MAX) cnt_d = cnt_q;
      else                  cnt_d = cnt_q + CNT_W'(1);
    end
  end

  assign flag_ok = (cnt_d == CNT_MAX);
  assign irq_req = |(status_d_i & mask_d_i);

  always_comb begin
    if (act_d) irq_d = flag_ok & fb_empty_i;
    else       irq_d = irq_req ^ pol_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      act_q_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      act_q_o <= act_d;
      irq_o   <= irq_d;
    end
  end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned SETTLE  = 38
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [NUM_EVT-1:0] wr_data_i,
  input  logic               rd_en_i,
  input  logic [1:0]         rd_addr_i,
  output logic [NUM_EVT-1:0] rd_data_o,
  input  logic               fb_rd_active_i,
  input  logic               fb_empty_i,
  output logic               irq_o
);

  logic [NUM_EVT-1:0] mask_q;
  logic [NUM_EVT-1:0] mask_d;
  ctrl_t              ctrl_q;
  logic               pol_d;
  logic               flag_en_d;
  logic [NUM_EVT-1:0] status_q;
  logic [NUM_EVT-1:0] status_d;
  logic               stat_clr;
  logic               fb_act_q;

  assign stat_clr = rd_en_i && (rd_addr_i == ADDR_STATUS);

  irqc_cfg_regs #(.NUM_EVT(NUM_EVT)) cfg_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .mask_q_o   (mask_q),
    .mask_d_o   (mask_d),
    .ctrl_q_o   (ctrl_q),
    .pol_d_o    (pol_d),
    .flag_en_d_o(flag_en_d)
  );

  irqc_status #(.NUM_EVT(NUM_EVT)) stat_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .mask_q_i  (mask_q),
    .poll_i    (ctrl_q.poll),
    .clr_i     (stat_clr),
    .status_q_o(status_q),
    .status_d_o(status_d)
  );

  irqc_pin #(.NUM_EVT(NUM_EVT), .SETTLE(SETTLE)) pin_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .status_d_i    (status_d),
    .mask_d_i      (mask_d),
    .pol_d_i       (pol_d),
    .flag_en_d_i   (flag_en_d),
    .fb_rd_active_i(fb_rd_active_i),
    .fb_empty_i    (fb_empty_i),
    .act_q_o       (fb_act_q),
    .irq_o         (irq_o)
  );

  always_comb begin
    unique case (rd_addr_i)
      ADDR_STATUS: rd_data_o = status_q;
      ADDR_MASK:   rd_data_o = mask_q;
      ADDR_CTRL:   rd_data_o = {{(NUM_EVT-CTRL_W){1'b0}}, ctrl_q};
      default:     rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned SETTLE  = 38
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               rd_en_i,
  input logic [1:0]         rd_addr_i,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] status_q,
  input logic [NUM_EVT-1:0] mask_q,
  input ctrl_t              ctrl_q,
  input logic               act_q
);

  logic rd_clr;
  assign rd_clr = rd_en_i && (rd_addr_i == ADDR_STATUS);

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr |=> (($past(status_q) & ~status_q) == '0));

  assert_masked_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.poll |=> ((status_q & ~$past(status_q) & ~$past(mask_q)) == '0));

  assert_poll_records_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.poll |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  assert_clear_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && (evt_i == '0)) |=> (status_q == '0));

  // R6 and R7: pin level outside a buffer takeover
  assert_pin_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> (irq_o == ((|(status_q & mask_q)) ^ ctrl_q.pol_low)));

  assert_flag_settle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((SETTLE > 1) && $rose(act_q)) |-> !irq_o);

  assert_takeover_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.flag_en |-> !act_q);

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NUM_EVT(NUM_EVT), .SETTLE(SETTLE)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .rd_en_i  (rd_en_i),
  .rd_addr_i(rd_addr_i),
  .irq_o    (irq_o),
  .status_q (status_q),
  .mask_q   (mask_q),
  .ctrl_q   (ctrl_q),
  .act_q    (fb_act_q)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;

  localparam int NE = 8;
  localparam int ST = 38;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [NE-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_addr = '0;
  logic [NE-1:0] rd_data;
  logic          fb_rd = 1'b0;
  logic          fb_empty = 1'b0;
  logic          irq;

  always #10 clk = ~clk;

  evt_irq_ctrl #(.NUM_EVT(NE), .SETTLE(ST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .fb_rd_active_i(fb_rd), .fb_empty_i(fb_empty), .irq_o(irq)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string phase = "R1";

  // Behavioural reference model, stepped on each rising edge
  logic [7:0] m_stat, m_mask;
  logic [2:0] m_ctrl;
  int         m_cnt;
  logic       m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_ctrl = 0; m_cnt = 0; m_irq = 0;
    end else begin
      logic [7:0] ns, nm, rec;
      logic [2:0] nc;
      bit         act;
      rec = m_ctrl[0] ? 8'hFF : m_mask;
      ns  = ((rd_en && rd_addr == 2'd0) ? 8'h00 : m_stat) | (evt & rec);
      nm  = (wr_en && wr_addr == 2'd1) ? wr_data : m_mask;
      nc  = (wr_en && wr_addr == 2'd2) ? wr_data[2:0] : m_ctrl;
      act = fb_rd && nc[2];
      if (!act) m_cnt = 0;
      else if (m_cnt < ST) m_cnt = m_cnt + 1;
      if (act) m_irq = (m_cnt == ST) ? fb_empty : 1'b0;
      else     m_irq = ((ns & nm) != 0) ^ nc[1];
      m_stat = ns; m_mask = nm; m_ctrl = nc;
    end
  end

  function automatic logic [7:0] model_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_stat;
      2'd1:    return m_mask;
      2'd2:    return {5'b0, m_ctrl};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // Every falling edge: compare pin and read port against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(phase, "model irq_o", int'(irq), int'(m_irq));
      chk(phase, "model rd_data_o", int'(rd_data), int'(model_rd(rd_addr)));
    end
  end

  task automatic idle();
    evt = '0; wr_en = 0; rd_en = 0;
  endtask

  // Hold the current inputs across exactly one rising edge
  task automatic step();
    @(negedge clk); #2;
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  task automatic ev(input logic [7:0] e);
    evt = e; step();
  endtask

  task automatic rd_clear(input logic [7:0] e);
    rd_en = 1; rd_addr = 2'd0; evt = e; step();
  endtask

  task automatic peek(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    chk(req, "read", int'(rd_data), int'(exp));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    // R1 reset state
    phase = "R1";
    peek("R1", 2'd0, 8'h00); peek("R1", 2'd1, 8'h00); peek("R1", 2'd2, 8'h00);
    chk("R1", "irq_o", int'(irq), 0);
    step();

    // R10 register write and readback
    phase = "R10";
    wr(2'd1, 8'h0C); peek("R10", 2'd1, 8'h0C);
    wr(2'd2, 8'hFF); peek("R10", 2'd2, 8'h07); peek("R10", 2'd3, 8'h00);
    chk("R7", "idle active-low pin", int'(irq), 1);
    wr(2'd2, 8'h00);

    // R2/R6 frame-end event recorded and raises pin
    phase = "R6";
    ev(8'h08); peek("R2", 2'd0, 8'h08);
    chk("R6", "irq_o after frame end", int'(irq), 1);

    // R5 clear on read, same-cycle event kept
    phase = "R5";
    rd_clear(8'h04); peek("R5", 2'd0, 8'h04);
    chk("R5", "irq_o after read", int'(irq), 1);
    rd_clear(8'h00); peek("R5", 2'd0, 8'h00);
    chk("R5", "irq_o cleared", int'(irq), 0);

    // R3 masked event dropped without poll
    phase = "R3";
    ev(8'h81); peek("R3", 2'd0, 8'h00);
    chk("R3", "irq_o masked", int'(irq), 0);

    // R4 poll mode records masked events, pin stays low
    phase = "R4";
    wr(2'd2, 8'h01);
    ev(8'h81); peek("R4", 2'd0, 8'h81);
    chk("R4", "irq_o masked in poll", int'(irq), 0);
    wr(2'd1, 8'h01);
    chk("R6", "irq_o after unmask", int'(irq), 1);
    rd_clear(8'h00);
    wr(2'd1, 8'h0C);

    // R7 polarity
    phase = "R7";
    wr(2'd2, 8'h02);
    chk("R7", "idle inverted", int'(irq), 1);
    ev(8'h08);
    chk("R7", "asserted low", int'(irq), 0);
    rd_clear(8'h00);
    chk("R7", "released", int'(irq), 1);

    // R8 buffer-empty takeover, active high despite polarity
    phase = "R8";
    wr(2'd2, 8'h06);
    fb_rd = 1; fb_empty = 1;
    for (int k = 1; k <= ST - 1; k++) begin
      step();
      if (k == 1) chk("R8", "flag before settle", int'(irq), 0);
    end
    chk("R8", "flag at edge SETTLE-1", int'(irq), 0);
    step();
    chk("R8", "flag valid at edge SETTLE", int'(irq), 1);
    fb_empty = 0; step();
    chk("R8", "flag follows empty low", int'(irq), 0);
    ev(8'h08);
    chk("R8", "event ignored on pin during takeover", int'(irq), 0);
    fb_empty = 1; step();
    chk("R8", "flag follows empty high", int'(irq), 1);

    // R9 return to interrupt role, and gating by flag enable
    phase = "R9";
    fb_rd = 0; step();
    chk("R9", "pin back to interrupt", int'(irq), 0);
    wr(2'd2, 8'h02);
    fb_rd = 1; step(); step();
    chk("R9", "burst ignored when disabled", int'(irq), 0);
    rd_clear(8'h00);
    chk("R9", "pin after clear", int'(irq), 1);
    fb_rd = 0; fb_empty = 0;

    // Mixed random traffic against the model
    phase = "R2 R6 mixed";
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(3) == 0) evt = 8'($urandom);
      if ($urandom_range(15) == 0) begin
        wr_en = 1; wr_addr = 2'($urandom_range(2, 1)); wr_data = 8'($urandom);
      end
      rd_addr = 2'($urandom);
      rd_en = ($urandom_range(7) == 0);
      if ($urandom_range(40) == 0) fb_rd = ~fb_rd;
      fb_empty = ($urandom_range(3) != 0);
      step();
    end

    finish_run();
  end

endmodule